// File: doc/BRIEF.md
# Watchdog Timer with Low-Power Gating

This block counts machine-cycle ticks and raises a one-cycle reset request when the count reaches a programmable limit. Firmware keeps the system alive by pulsing a service strobe before the limit is hit. A 3-bit select register picks one of eight limits. Each limit is one less than a power of two, and each code doubles the one below it. An enable input turns the whole watchdog off and holds the count at zero.

The counter follows the core's low-power modes. In idle it keeps counting. In power-down it freezes and cannot raise a request. When power-down ends while the active-low external interrupt pin is still low, the count stays frozen until the pin goes high again. A hardware reset taken during power-down returns the block to its normal post-reset state.

The control is a five-state machine:
- `ST_OFF`: disabled, count held at zero.
- `ST_RUN`: counting.
- `ST_IDLE`: counting while the core idles.
- `ST_SLEEP`: power-down, frozen.
- `ST_WAKE_HOLD`: woken by interrupt, frozen while the pin is low.

Transitions are as follows:
- Enable low sends every state to `ST_OFF`.
- `ST_OFF` moves to `ST_RUN` when enabled.
- `ST_RUN` moves to `ST_SLEEP` on power-down. Otherwise it moves to `ST_IDLE` on idle.
- `ST_IDLE` moves to `ST_SLEEP` on power-down. It returns to `ST_RUN` when idle drops.
- `ST_SLEEP`, once power-down drops, moves to `ST_RUN` if the pin is high and to `ST_WAKE_HOLD` if it is low.
- `ST_WAKE_HOLD` moves to `ST_RUN` once the pin is high.

Top module: `wdog_timer`

## Requirements
- R1: With select value S (0 to 7, bits [2:0] of the write data), consecutive reset requests under continuous ticking are 2^(BASE_EXP+S) − 1 qualified ticks apart. BASE_EXP defaults to 14, so the span runs from 2^14−1 to 2^21−1.
- R2: After reset the select value is 000, the request output is low and the state is `ST_OFF`. With enable high and a tick every cycle, the first request appears 2^BASE_EXP cycles after reset is released: one cycle to enter `ST_RUN`, then 2^BASE_EXP−1 counting cycles.
- R3: The reset request is high for exactly one clock cycle, and the count restarts from zero after it.
- R4: The count advances only in cycles where the machine-cycle tick is high. A tick every other cycle doubles the interval.
- R5: A service strobe clears the count to zero. If it falls in the same cycle as a timeout, the service wins and no request is raised.
- R6: A new select value applies to the next comparison without clearing the count. If the count already meets or exceeds the new limit, the request fires on the next qualified tick.
- R7: While enable is low, the count is held at zero and no request is raised. Counting restarts from zero once enable returns.
- R8: In idle mode the count keeps advancing, so the interval is unchanged.
- R9: In power-down the count does not advance and no request is raised. Each cycle spent frozen delays the next request by one cycle.
- R10: After power-down ends with the interrupt pin low, the count stays frozen until the pin is high. A low pin outside this wake path has no effect.
- R11: A hardware reset taken during power-down restores the R2 state, including select 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| wd_en | input | 1 | Watchdog enable; low holds the count at zero |
| sel_we | input | 1 | Write strobe for the timeout select register |
| sel_wdata | input | SEL_W | Timeout select value to write |
| svc | input | 1 | Service strobe; clears the count |
| mc_tick | input | 1 | Machine-cycle tick; the count advances only when high |
| idle_mode | input | 1 | Core is in idle mode |
| pd_mode | input | 1 | Core is in power-down mode |
| ext_int_n | input | 1 | Active-low external interrupt pin |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Service and timeout are the two functions that can fall in the same cycle. The bench waits for a request and then counts one cycle short of the next limit. It raises the service strobe so that the strobe is sampled on the very edge that would fire. It then requires the request to stay low on that cycle and the next request to arrive a full interval after the service edge. A select write that shrinks the limit below the running count is the second collision. It must fire exactly one cycle after the write takes effect.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_RUN,
        ST_IDLE,
        ST_SLEEP,
        ST_WAKE_HOLD
    } wd_state_t;
endpackage

// File: rtl/wdog_sel_reg.sv
module wdog_sel_reg #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] sel_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (we) begin
            sel_q <= wdata;
        end
    end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wd_en,
    input  logic      idle_mode,
    input  logic      pd_mode,
    input  logic      ext_int_n,
    output wd_state_t state,
    output logic      run,
    output logic      hold_zero
);
    wd_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (!wd_en) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:       state_nx = ST_RUN;
                ST_RUN: begin
                    if (pd_mode)        state_nx = ST_SLEEP;
                    else if (idle_mode) state_nx = ST_IDLE;
                end
                ST_IDLE: begin
                    if (pd_mode)         state_nx = ST_SLEEP;
                    else if (!idle_mode) state_nx = ST_RUN;
                end
                ST_SLEEP: begin
                    if (!pd_mode) state_nx = ext_int_n ? ST_RUN : ST_WAKE_HOLD;
                end
                ST_WAKE_HOLD: begin
                    if (ext_int_n) state_nx = ST_RUN;
                end
                default:      state_nx = ST_OFF;
            endcase
        end
    end

    always_comb begin
        run       = wd_en && ((state == ST_RUN) || (state == ST_IDLE));
        hold_zero = !wd_en || (state == ST_OFF);
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int BASE_EXP = 14,
    parameter int SEL_W    = 3,
    parameter int CNT_W    = BASE_EXP + (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold_zero,
    input  logic             svc,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] cnt,
    output logic             fire
);
    localparam int NUM_SEL = 1 << SEL_W;

    logic [CNT_W-1:0] last_tab [NUM_SEL];
    logic [CNT_W-1:0] last_sel;

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_last
        assign last_tab[g] = CNT_W'((64'(1) << (BASE_EXP + g)) - 64'(2));
    end

    assign last_sel = last_tab[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (hold_zero || svc) begin
                cnt <= '0;
            end else if (run && tick) begin
                if (cnt >= last_sel) begin
                    cnt  <= '0;
                    fire <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int BASE_EXP = 14,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wd_en,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             svc,
    input  logic             mc_tick,
    input  logic             idle_mode,
    input  logic             pd_mode,
    input  logic             ext_int_n,
    output logic             rst_req
);
    localparam int CNT_W = BASE_EXP + (1 << SEL_W) - 1;

    wd_state_t        state;
    logic             run;
    logic             hold_zero;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt;

    wdog_sel_reg #(.SEL_W(SEL_W)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sel_we),
        .wdata (sel_wdata),
        .sel_q (sel_q)
    );

    wdog_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wd_en     (wd_en),
        .idle_mode (idle_mode),
        .pd_mode   (pd_mode),
        .ext_int_n (ext_int_n),
        .state     (state),
        .run       (run),
        .hold_zero (hold_zero)
    );

    wdog_counter #(
        .BASE_EXP (BASE_EXP),
        .SEL_W    (SEL_W),
        .CNT_W    (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .hold_zero (hold_zero),
        .svc       (svc),
        .tick      (mc_tick),
        .sel       (sel_q),
        .cnt       (cnt),
        .fire      (rst_req)
    );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wd_en,
    input logic             svc,
    input logic             mc_tick,
    input logic             ext_int_n,
    input logic             rst_req,
    input wd_state_t        state,
    input logic [CNT_W-1:0] cnt
);
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_pulse_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cnt == '0));

    p_tick_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_en && !mc_tick && !svc) |=> ($stable(cnt) && !rst_req));

    p_svc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> ((cnt == '0) && !rst_req));

    p_disable_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en |=> ((cnt == '0) && !rst_req));

    p_pd_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SLEEP) && wd_en && !svc) |=> ($stable(cnt) && !rst_req));

    p_wake_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WAKE_HOLD) && wd_en && !svc && !ext_int_n)
            |=> ((state == ST_WAKE_HOLD) && $stable(cnt) && !rst_req));
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wd_en     (wd_en),
    .svc       (svc),
    .mc_tick   (mc_tick),
    .ext_int_n (ext_int_n),
    .rst_req   (rst_req),
    .state     (state),
    .cnt       (cnt)
);

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
    localparam int B = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wd_en = 1'b1;
    logic       sel_we = 1'b0;
    logic [2:0] sel_wdata = 3'd0;
    logic       svc = 1'b0;
    logic       mc_tick = 1'b1;
    logic       idle_mode = 1'b0;
    logic       pd_mode = 1'b0;
    logic       ext_int_n = 1'b1;
    logic       rst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdog_timer #(.BASE_EXP(B), .SEL_W(3)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wd_en     (wd_en),
        .sel_we    (sel_we),
        .sel_wdata (sel_wdata),
        .svc       (svc),
        .mc_tick   (mc_tick),
        .idle_mode (idle_mode),
        .pd_mode   (pd_mode),
        .ext_int_n (ext_int_n),
        .rst_req   (rst_req)
    );

    function automatic int tmo(int s);
        return (1 << (B + s)) - 1;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rst_req && n < 20000);
    endtask

    task automatic wr_sel(int s);
        sel_we = 1'b1;
        sel_wdata = 3'(s);
        @(negedge clk);
        sel_we = 1'b0;
    endtask

    task automatic quiet(int cyc, string req);
        int hits = 0;
        repeat (cyc) begin
            @(negedge clk);
            if (rst_req) hits++;
        end
        chk(hits == 0, req, hits, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(rst_req == 1'b0, "R2 reset output", int'(rst_req), 0);
        rst_n = 1'b1;
        wait_pulse(n);
        chk(n == tmo(0) + 1, "R2 first request", n, tmo(0) + 1);
        @(negedge clk);
        chk(rst_req == 1'b0, "R3 one-cycle pulse", int'(rst_req), 0);
        wait_pulse(n);
        chk(n == tmo(0) - 1, "R3 restart after pulse", n, tmo(0) - 1);

        // R1: sweep all eight select codes
        for (int s = 0; s < 8; s++) begin
            wr_sel(s);
            wait_pulse(n);
            chk(n + 1 == tmo(s), $sformatf("R1 interval sel=%0d", s), n + 1, tmo(s));
        end
        wr_sel(0);
        wait_pulse(n);
        chk(n + 1 == tmo(0), "R1 back to sel 0", n + 1, tmo(0));

        // R4: tick every other cycle
        mc_tick = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            mc_tick = n[0];
        end while (!rst_req && n < 1000);
        mc_tick = 1'b1;
        chk(n == 2 * tmo(0), "R4 half-rate tick", n, 2 * tmo(0));

        // R10: low pin during normal run has no effect
        ext_int_n = 1'b0;
        wait_pulse(n);
        ext_int_n = 1'b1;
        chk(n == tmo(0), "R10 pin low while running", n, tmo(0));

        // R8: idle keeps counting
        idle_mode = 1'b1;
        wait_pulse(n);
        idle_mode = 1'b0;
        chk(n == tmo(0), "R8 idle interval", n, tmo(0));

        // R5: service in the timeout cycle wins
        repeat (tmo(0) - 1) @(negedge clk);
        svc = 1'b1;
        @(negedge clk);
        svc = 1'b0;
        chk(rst_req == 1'b0, "R5 service beats timeout", int'(rst_req), 0);
        wait_pulse(n);
        chk(n == tmo(0), "R5 interval after service", n, tmo(0));

        // R6: shrinking the limit below the count fires next tick
        wr_sel(3);
        repeat (199) @(negedge clk);
        wr_sel(0);
        chk(rst_req == 1'b0, "R6 no fire on write edge", int'(rst_req), 0);
        @(negedge clk);
        chk(rst_req == 1'b1, "R6 immediate fire", int'(rst_req), 1);

        // R6: growing the limit keeps the count
        repeat (9) @(negedge clk);
        wr_sel(1);
        wait_pulse(n);
        chk(n + 10 == tmo(1), "R6 no clear on select change", n + 10, tmo(1));
        wr_sel(0);
        wait_pulse(n);
        chk(n + 1 == tmo(0), "R6 resync sel 0", n + 1, tmo(0));

        // R9: power-down freezes
        repeat (20) @(negedge clk);
        pd_mode = 1'b1;
        quiet(300, "R9 no request in power-down");
        pd_mode = 1'b0;
        wait_pulse(n);
        chk(n == tmo(0) - 20, "R9 frozen cycles add delay", n, tmo(0) - 20);

        // R10: wake with pin low holds until pin high
        repeat (20) @(negedge clk);
        pd_mode = 1'b1;
        quiet(100, "R9 power-down before wake");
        pd_mode = 1'b0;
        ext_int_n = 1'b0;
        quiet(150, "R10 held while pin low");
        ext_int_n = 1'b1;
        wait_pulse(n);
        chk(n == tmo(0) - 20, "R10 resume after pin high", n, tmo(0) - 20);

        // R7: enable low holds zero
        repeat (30) @(negedge clk);
        wd_en = 1'b0;
        quiet(5, "R7 no request while disabled");
        wd_en = 1'b1;
        wait_pulse(n);
        chk(n == tmo(0) + 1, "R7 restart from zero", n, tmo(0) + 1);

        // R11: hardware reset during power-down
        wr_sel(3);
        repeat (20) @(negedge clk);
        pd_mode = 1'b1;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        pd_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk(rst_req == 1'b0, "R11 output low in reset", int'(rst_req), 0);
        rst_n = 1'b1;
        wait_pulse(n);
        chk(n == tmo(0) + 1, "R11 post-reset interval sel 000", n, tmo(0) + 1);

        finish_run();
    end
endmodule